// File: doc/BRIEF.md
# Loop Mode Controller with Holdover Frequency Store

This block decides the operating mode of a digital PLL and keeps the frequency word the loop falls back on when its reference disappears. Every clock it looks at a reference-valid flag and a lock indication and moves between four modes: free-run, acquiring, locked and holdover. The active loop bandwidth setting follows the mode. There is a wide setting while acquiring and a narrow one once locked. The damping code passes straight through to the loop filter.

While locked, each frequency word that the loop filter strobes in feeds three first-order IIR averages, each with its own shift-based coefficient. These give a short, a medium and a long memory, scaled down from spans of roughly one second, a few minutes and an hour and a half. The last raw sample is also kept. A select input picks which of these four stored values is presented as the holdover frequency. The averages stop moving as soon as the loop leaves the locked mode, so holdover starts from a clean history.

Top module: `loop_mode_ctrl`

## Requirements
- R1: After reset the mode output is free-run (code 0), all stored frequency values are zero, and the bandwidth output equals the acquisition setting.
- R2: Mode codes are 0 free-run, 1 acquiring, 2 locked, 3 holdover. Free-run with a valid reference moves to acquiring at the next edge. Acquiring with a valid reference and lock asserted moves to locked. Locked with a valid reference but lock deasserted returns to acquiring.
- R3: In locked mode, a low reference-valid moves the mode to holdover at the very next clock edge.
- R4: In acquiring mode, a low reference-valid moves the mode to holdover if any locked frequency sample has been stored since reset, and to free-run otherwise.
- R5: In holdover, a valid reference moves the mode to acquiring, never directly to locked. Without one, holdover persists.
- R6: The bandwidth output equals the locked setting while the mode is locked and the acquisition setting in every other mode.
- R7: The 3-bit damping output equals the damping input in every cycle.
- R8: A frequency strobe in locked mode stores the sample as the instantaneous value. The first such strobe after reset loads every average accumulator with sample·2^F. Each later strobe updates accumulator k as acc += ((sample·2^F) − acc) >>> S_k (arithmetic shift, S = 2, 5, 8 by default, F = 8). The reported average is acc >>> F.
- R9: Stored values change only on a frequency strobe while the mode is locked. Strobes in free-run, acquiring or holdover leave the holdover output unchanged.
- R10: The holdover output shows the instantaneous value for select 0, the short average for 1, the medium for 2 and the long for 3. It follows the select input in the same cycle, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Selected reference is present and qualified |
| lock_ind | input | 1 | Phase detector reports lock |
| freq_vld | input | 1 | Strobe: freq_in carries a new loop-filter frequency word |
| freq_in | input | FREQ_W | Signed frequency word from the loop filter |
| avg_sel | input | 2 | Holdover source: 0 instant, 1 short, 2 medium, 3 long |
| bw_acq_cfg | input | BW_W | Bandwidth setting used outside locked mode |
| bw_lock_cfg | input | BW_W | Bandwidth setting used in locked mode |
| damp_cfg | input | 3 | Damping code, one of five factors |
| mode | output | 2 | Current operating mode |
| bw_sel_out | output | BW_W | Active bandwidth setting |
| damp_out | output | 3 | Damping code to the loop filter |
| hold_freq | output | FREQ_W | Frequency word for holdover |

## Verification
The bench drops the reference in locked mode and expects holdover one edge later; a design with a qualification delay would linger in locked. It removes the reference during acquisition both before and after any locked sample exists, which catches a controller that always falls to free-run or always to holdover. It pulses the frequency strobe during holdover and acquisition and checks that the holdover word does not drift, and it restores the reference in holdover to confirm the loop reacquires rather than jumping straight to locked. Random frequency words are compared against a bench model of the three shift-based averages, including the first-sample seeding, which a design that skipped seeding would fail with large early errors.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_ACQ    = 2'd1,
    MODE_LOCKED = 2'd2,
    MODE_HOLD   = 2'd3
  } lmc_mode_e;

  localparam int NUM_AVG = 3;
endpackage

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
  import lmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_valid,
  input  logic      lock_ind,
  input  logic      has_hist,
  output lmc_mode_e mode_q
);
  lmc_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_FREE:   if (ref_valid) mode_d = MODE_ACQ;
      MODE_ACQ: begin
        if (!ref_valid)    mode_d = has_hist ? MODE_HOLD : MODE_FREE;
        else if (lock_ind) mode_d = MODE_LOCKED;
      end
      MODE_LOCKED: begin
        if (!ref_valid)     mode_d = MODE_HOLD;
        else if (!lock_ind) mode_d = MODE_ACQ;
      end
      MODE_HOLD:   if (ref_valid) mode_d = MODE_ACQ;
      default:     mode_d = MODE_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FREE;
    else        mode_q <= mode_d;
  end

  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOCKED && !ref_valid) |=> (mode_q == MODE_HOLD)); // R3
  AST_HOLD_NO_DIRECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOLD) |=> (mode_q != MODE_LOCKED)); // R5
  AST_FREE_NO_DIRECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE) |=> (mode_q != MODE_LOCKED)); // R2
  AST_ACQ_LOSS_NO_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACQ && !ref_valid && !has_hist) |=> (mode_q == MODE_FREE)); // R4
endmodule

// File: rtl/lmc_iir_avg.sv
module lmc_iir_avg #(
  parameter int FREQ_W = 24,
  parameter int FRAC_W = 8,
  parameter int SHIFT  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic                     seed,
  input  logic signed [FREQ_W-1:0] sample,
  output logic signed [FREQ_W-1:0] avg
);
  localparam int ACC_W = FREQ_W + FRAC_W;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W:0]   diff;
  logic signed [ACC_W:0]   step;

  assign scaled = {sample, {FRAC_W{1'b0}}};
  assign diff   = {scaled[ACC_W-1], scaled} - {acc_q[ACC_W-1], acc_q};
  assign step   = diff >>> SHIFT;

  always_comb begin
    acc_d = acc_q;
    if (upd_en) begin
      if (seed) acc_d = scaled;
      else      acc_d = acc_q + step[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign avg = acc_q[ACC_W-1:FRAC_W];

  AST_AVG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(avg)); // R9
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && seed) |=> (avg == $past(sample))); // R8
endmodule

// File: rtl/loop_mode_ctrl.sv
module loop_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int FREQ_W    = 24,
  parameter int FRAC_W    = 8,
  parameter int BW_W      = 5,
  parameter int SH_SHORT  = 2,
  parameter int SH_MEDIUM = 5,
  parameter int SH_LONG   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_valid,
  input  logic                     lock_ind,
  input  logic                     freq_vld,
  input  logic signed [FREQ_W-1:0] freq_in,
  input  logic [1:0]               avg_sel,
  input  logic [BW_W-1:0]          bw_acq_cfg,
  input  logic [BW_W-1:0]          bw_lock_cfg,
  input  logic [2:0]               damp_cfg,
  output logic [1:0]               mode,
  output logic [BW_W-1:0]          bw_sel_out,
  output logic [2:0]               damp_out,
  output logic signed [FREQ_W-1:0] hold_freq
);
  lmc_mode_e               mode_q;
  logic                    hist_q, hist_d;
  logic                    upd_en;
  logic signed [FREQ_W-1:0] inst_q, inst_d;
  logic signed [FREQ_W-1:0] avg_w [NUM_AVG];

  lmc_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_valid(ref_valid),
    .lock_ind (lock_ind),
    .has_hist (hist_q),
    .mode_q   (mode_q)
  );

  assign upd_en = freq_vld && (mode_q == MODE_LOCKED);

  always_comb begin
    hist_d = hist_q;
    inst_d = inst_q;
    if (upd_en) begin
      hist_d = 1'b1;
      inst_d = freq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      inst_q <= '0;
    end else begin
      hist_q <= hist_d;
      inst_q <= inst_d;
    end
  end

  for (genvar gi = 0; gi < NUM_AVG; gi++) begin : g_avg
    localparam int SH = (gi == 0) ? SH_SHORT : (gi == 1) ? SH_MEDIUM : SH_LONG;
    lmc_iir_avg #(
      .FREQ_W(FREQ_W),
      .FRAC_W(FRAC_W),
      .SHIFT (SH)
    ) u_avg (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_en(upd_en),
      .seed  (!hist_q),
      .sample(freq_in),
      .avg   (avg_w[gi])
    );
  end

  always_comb begin
    case (avg_sel)
      2'd1:    hold_freq = avg_w[0];
      2'd2:    hold_freq = avg_w[1];
      2'd3:    hold_freq = avg_w[2];
      default: hold_freq = inst_q;
    endcase
  end

  assign mode       = mode_q;
  assign bw_sel_out = (mode_q == MODE_LOCKED) ? bw_lock_cfg : bw_acq_cfg;
  assign damp_out   = damp_cfg;

  AST_HOLD_WORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOLD) |=> ($stable(avg_sel) -> $stable(hold_freq))); // R9
  AST_HIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q |=> hist_q); // R4
  AST_ACQ_LOSS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACQ && !ref_valid && hist_q) |=> (mode == 2'd3)); // R4
endmodule

// File: tb/loop_mode_ctrl_test.sv
`timescale 1ns/1ps
module loop_mode_ctrl_test;
  localparam int FW = 24;
  localparam int FR = 8;
  localparam int BW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_valid, lock_ind, freq_vld;
  logic signed [FW-1:0] freq_in;
  logic [1:0] avg_sel;
  logic [BW-1:0] bw_acq_cfg, bw_lock_cfg;
  logic [2:0] damp_cfg;
  logic [1:0] mode;
  logic [BW-1:0] bw_sel_out;
  logic [2:0] damp_out;
  logic signed [FW-1:0] hold_freq;

  always #4 clk = ~clk;

  loop_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .lock_ind(lock_ind),
    .freq_vld(freq_vld), .freq_in(freq_in), .avg_sel(avg_sel),
    .bw_acq_cfg(bw_acq_cfg), .bw_lock_cfg(bw_lock_cfg), .damp_cfg(damp_cfg),
    .mode(mode), .bw_sel_out(bw_sel_out), .damp_out(damp_out), .hold_freq(hold_freq)
  );

  int n_chk = 0;
  int n_fail = 0;

  int     m_mode;
  bit     m_hist;
  longint m_acc [3];
  longint m_inst;
  string  m_tag;

  function automatic int shift_of(int k);
    return (k == 0) ? 2 : (k == 1) ? 5 : 8;
  endfunction

  function automatic longint exp_hold(int sel);
    if (sel == 0) return m_inst;
    return m_acc[sel-1] >>> FR;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_hist = 0; m_inst = 0;
    foreach (m_acc[k]) m_acc[k] = 0;
  endtask

  task automatic model_edge();
    longint x;
    int nxt;
    x = longint'(freq_in);
    if (m_mode == 2 && freq_vld) begin
      for (int k = 0; k < 3; k++) begin
        if (!m_hist) m_acc[k] = x <<< FR;
        else m_acc[k] = m_acc[k] + (((x <<< FR) - m_acc[k]) >>> shift_of(k));
      end
      m_inst = x;
      m_hist = 1;
    end
    nxt = m_mode;
    m_tag = "R2";
    case (m_mode)
      0: if (ref_valid) nxt = 1;
      1: if (!ref_valid) begin nxt = m_hist ? 3 : 0; m_tag = "R4"; end
         else if (lock_ind) nxt = 2;
      2: if (!ref_valid) begin nxt = 3; m_tag = "R3"; end
         else if (!lock_ind) nxt = 1;
      default: begin m_tag = "R5"; if (ref_valid) nxt = 1; end
    endcase
    m_mode = nxt;
  endtask

  task automatic check_outputs();
    chk(m_tag, mode, m_mode);
    chk("R6", bw_sel_out, (m_mode == 2) ? bw_lock_cfg : bw_acq_cfg);
    chk("R7", damp_out, damp_cfg);
    chk((m_mode == 2) ? "R8" : "R9", hold_freq, exp_hold(avg_sel));
  endtask

  task automatic cyc(bit rv, bit lk, bit fv, longint fi, int sel);
    ref_valid = rv; lock_ind = lk; freq_vld = fv;
    freq_in = fi[FW-1:0]; avg_sel = sel[1:0];
    damp_cfg = 3'($urandom_range(0, 4));
    @(posedge clk);
    model_edge();
    #2;
    check_outputs();
    @(negedge clk);
  endtask

  function automatic longint rnd_freq();
    return longint'($urandom_range(0, 2000000)) - 1000000;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    ref_valid = 0; lock_ind = 0; freq_vld = 0; freq_in = '0; avg_sel = 0;
    damp_cfg = 3'd2;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", mode, 0);
    chk("R1", bw_sel_out, bw_acq_cfg);
    for (int s = 0; s < 4; s++) begin
      avg_sel = s[1:0];
      #1;
      chk("R1", hold_freq, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    bw_acq_cfg  = 5'd21;
    bw_lock_cfg = 5'd6;
    do_reset();

    // R4: reference lost during acquisition with no locked history -> free-run
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 500, 1);
    chk("R4", mode, 0);

    // R2/R8: lock, seed, then several updates
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    chk("R2", mode, 2);
    cyc(1, 1, 1, 40000, 1);
    chk("R8", hold_freq, 40000);
    for (int i = 0; i < 20; i++) cyc(1, 1, 1, 40000 + 100 * i, i % 4);

    // R3: single-cycle move to holdover
    cyc(0, 1, 1, 999999, 3);
    chk("R3", mode, 3);
    // R9/R10: strobes in holdover leave stores untouched, sweep selects
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, rnd_freq(), i % 4);
    // R5: return of reference goes to acquisition first
    cyc(1, 1, 1, 7, 2);
    chk("R5", mode, 1);
    // R9: strobe during acquisition ignored
    cyc(1, 0, 1, -300000, 0);
    // R4: loss in acquisition after history -> holdover
    cyc(0, 0, 0, 0, 1);
    chk("R4", mode, 3);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 99) < 92), ($urandom_range(0, 99) < 75),
          ($urandom_range(0, 1) == 1), rnd_freq(), $urandom_range(0, 3));
    end

    // Second reset then acquisition loss goes to free-run again (R1, R4)
    @(negedge clk);
    do_reset();
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R4", mode, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule